// File: doc/BRIEF.md
# One-Shot and Periodic Tick Timers

This block holds two 32-bit tick timers behind one small register slave. One timer counts down once and then disarms itself. The other reloads after every expiry and fires at a fixed period. Both timers advance only on cycles where `tick_i` is high, so the time base comes from whatever tick enable the surrounding logic supplies.

Software programs a timer by writing its set-point. A nonzero value N arms the timer to fire N ticks later. Zero stops the timer. Each timer has a second, read-only register that shows the live count of ticks left before the next expiry. When a timer expires it raises its own output for one cycle, in the same cycle as the tick that ends the count.

The slave takes a request, a write flag, a 6-bit byte offset, an access size in bytes, and a 32-bit data word. Bits [31:24] of the word carry the most significant byte. Reads are combinational and return the value for the current offset.

Top module: `tick_timer_pair`

## Requirements
- R1: After reset, both set-points and both remaining counts read 0, `err_o` is 0, and neither expiry output is high.
- R2: Writing a nonzero N, with size 4, to the set-point register sets both its readback and its remaining count to N. The countdown set-point is at offset 0x20 and the periodic set-point is at 0x28. Each cycle with `tick_i` high then lowers the remaining count by 1. The countdown remaining count is at 0x24 and the periodic remaining count is at 0x2C.
- R3: The countdown expires on the Nth tick after the write. On that tick `cd_expire_o` is high for exactly that cycle. Afterwards its set-point and remaining count both read 0, and no further pulses follow.
- R4: The periodic timer raises `per_expire_o` on every Nth tick and then reloads its remaining count to N. Its set-point stays at N.
- R5: Writing 0 to a set-point stops that timer. Its remaining count reads 0 and it produces no more pulses.
- R6: Writing a new nonzero value to a running timer drops the old count and restarts the timer from the new value.
- R7: If a set-point write and an expiring tick fall in the same cycle, the write wins. No pulse is produced and the written value is loaded.
- R8: A timer-register access whose size is not 4 sets `err_o`, which stays high until reset. Such an access changes no register, and such a read returns 0.
- R9: Writes to the remaining-count offsets (0x24 and 0x2C) are ignored.
- R10: A read at any offset other than the four timer offsets returns 0.
- R11: On cycles with `tick_i` low and no write, the remaining counts do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Tick enable; timers advance only when high |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Byte offset within the window |
| size_i | input | 3 | Access size in bytes; only 4 is legal |
| wdata_i | input | 32 | Write data, most significant byte on [31:24] |
| rdata_o | output | 32 | Read data, combinational from the current request |
| err_o | output | 1 | Sticky flag for a bad-size access |
| cd_expire_o | output | 1 | Countdown expiry pulse |
| per_expire_o | output | 1 | Periodic expiry pulse |

## Verification
Read data and the expiry pulses are combinational. The bench therefore samples them one time unit after it drives inputs at a falling edge, before the next rising edge. A write takes effect at the rising edge that follows it, so every readback is issued at a later falling edge. The bench counts expiry pulses during each tick cycle. It checks that an N-tick program yields its pulse on the Nth tick and not before. The same-cycle case drives the write and the expiring tick together and checks for no pulse in that very cycle.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam int SIZE_W = 3;
  localparam logic [SIZE_W-1:0] FULL_SIZE = 3'd4;

  localparam logic [ADDR_W-1:0] OFF_CD_SET  = 6'h20;
  localparam logic [ADDR_W-1:0] OFF_CD_LEFT = 6'h24;
  localparam logic [ADDR_W-1:0] OFF_PR_SET  = 6'h28;
  localparam logic [ADDR_W-1:0] OFF_PR_LEFT = 6'h2C;

  localparam int NUM_TMR = 2;
  localparam int IDX_CD  = 0;
  localparam int IDX_PR  = 1;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CD_SET,
    SEL_CD_LEFT,
    SEL_PR_SET,
    SEL_PR_LEFT
  } reg_sel_e;
endpackage

// File: rtl/tick_timer_unit.sv
module tick_timer_unit #(
  parameter int CNT_W    = 32,
  parameter bit PERIODIC = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] setpt_o,
  output logic [CNT_W-1:0] remain_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] setpt_q, remain_q;
  logic [CNT_W-1:0] reload_val, setpt_after;
  logic             last_tick;

  assign last_tick = tick_i && (remain_q == ONE);

  generate
    if (PERIODIC) begin : g_periodic
      assign reload_val  = setpt_q;
      assign setpt_after = setpt_q;
    end else begin : g_oneshot
      assign reload_val  = '0;
      assign setpt_after = '0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      setpt_q  <= '0;
      remain_q <= '0;
    end else if (wr_i) begin
      setpt_q  <= wdata_i;
      remain_q <= wdata_i;
    end else if (last_tick) begin
      setpt_q  <= setpt_after;
      remain_q <= reload_val;
    end else if (tick_i && remain_q != '0) begin
      remain_q <= remain_q - ONE;
    end
  end

  // write takes priority over an expiring tick
  assign expire_o = last_tick && !wr_i;
  assign setpt_o  = setpt_q;
  assign remain_o = remain_q;

  AST_STOPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (setpt_q == '0) |-> (remain_q == '0)); // R5
  AST_LEFT_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    remain_q <= setpt_q); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_i) |=> $stable(remain_q)); // R11

  generate
    if (PERIODIC) begin : g_ast_pr
      AST_PERIOD_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_o |=> (remain_q == $past(setpt_q) && setpt_q == $past(setpt_q))); // R4
    end else begin : g_ast_cd
      AST_ONESHOT_DISARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_o |=> (setpt_q == '0 && remain_q == '0)); // R3
    end
  endgenerate
endmodule

// File: rtl/tick_timer_decode.sv
module tick_timer_decode
  import tick_timer_pkg::*;
(
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  output reg_sel_e          sel_o,
  output logic              rd_ok_o,
  output logic              cd_wr_o,
  output logic              pr_wr_o,
  output logic              err_set_o
);
  logic size_ok, hit;

  always_comb begin
    unique case (addr_i)
      OFF_CD_SET:  sel_o = SEL_CD_SET;
      OFF_CD_LEFT: sel_o = SEL_CD_LEFT;
      OFF_PR_SET:  sel_o = SEL_PR_SET;
      OFF_PR_LEFT: sel_o = SEL_PR_LEFT;
      default:     sel_o = SEL_NONE;
    endcase
  end

  assign size_ok   = (size_i == FULL_SIZE);
  assign hit       = req_i && (sel_o != SEL_NONE);
  assign rd_ok_o   = hit && !we_i && size_ok;
  assign cd_wr_o   = hit && we_i && size_ok && (sel_o == SEL_CD_SET);
  assign pr_wr_o   = hit && we_i && size_ok && (sel_o == SEL_PR_SET);
  assign err_set_o = hit && !size_ok;
endmodule

// File: rtl/tick_timer_pair.sv
module tick_timer_pair
  import tick_timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              cd_expire_o,
  output logic              per_expire_o
);
  reg_sel_e          sel;
  logic              rd_ok, err_set;
  logic [NUM_TMR-1:0] wr, expire;
  logic [DATA_W-1:0] setpt [NUM_TMR];
  logic [DATA_W-1:0] remain [NUM_TMR];
  logic              err_q;

  tick_timer_decode u_decode (
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .size_i    (size_i),
    .sel_o     (sel),
    .rd_ok_o   (rd_ok),
    .cd_wr_o   (wr[IDX_CD]),
    .pr_wr_o   (wr[IDX_PR]),
    .err_set_o (err_set)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    tick_timer_unit #(
      .CNT_W    (DATA_W),
      .PERIODIC (g == IDX_PR)
    ) u_unit (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .wr_i     (wr[g]),
      .wdata_i  (wdata_i),
      .setpt_o  (setpt[g]),
      .remain_o (remain[g]),
      .expire_o (expire[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_q <= 1'b0;
    else if (err_set) err_q <= 1'b1;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_ok) begin
      unique case (sel)
        SEL_CD_SET:  rdata_o = setpt[IDX_CD];
        SEL_CD_LEFT: rdata_o = remain[IDX_CD];
        SEL_PR_SET:  rdata_o = setpt[IDX_PR];
        SEL_PR_LEFT: rdata_o = remain[IDX_PR];
        default:     rdata_o = '0;
      endcase
    end
  end

  assign err_o        = err_q;
  assign cd_expire_o  = expire[IDX_CD];
  assign per_expire_o = expire[IDX_PR];

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R8
  AST_BAD_SIZE_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && size_i != FULL_SIZE && !tick_i) |=>
      (setpt[IDX_CD] == $past(setpt[IDX_CD]) && setpt[IDX_PR] == $past(setpt[IDX_PR]))); // R8
endmodule

// File: tb/tick_timer_pair_tb.sv
module tick_timer_pair_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [2:0]  size_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        err_o, cd_expire_o, per_expire_o;

  int checks = 0;
  int failures = 0;

  always #4 clk_i = ~clk_i;

  tick_timer_pair dut_i (
    .clk_i, .rst_ni, .tick_i, .req_i, .we_i, .addr_i, .size_i,
    .wdata_i, .rdata_o, .err_o, .cd_expire_o, .per_expire_o
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", rq, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [2:0] sz, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; size_i = sz; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, input logic [2:0] sz, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a; size_i = sz;
    #1 d = rdata_o;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic run_ticks(input int n, output int cd_n, output int pr_n);
    cd_n = 0; pr_n = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      tick_i = 1'b1;
      #1;
      if (cd_expire_o) cd_n++;
      if (per_expire_o) pr_n++;
      @(negedge clk_i);
      tick_i = 1'b0;
    end
  endtask

  // {op[1:0], req[3:0], addr[5:0], data[31:0], exp[31:0]}; op 0=wr 1=rd 2=ticks
  // tick exp: [31:16] periodic pulses, [15:0] countdown pulses
  localparam int NV = 32;
  localparam logic [75:0] VEC [NV] = '{
    {2'd1, 4'd1,  6'h20, 32'd0,          32'd0},          // R1
    {2'd1, 4'd1,  6'h24, 32'd0,          32'd0},          // R1
    {2'd1, 4'd1,  6'h2C, 32'd0,          32'd0},          // R1
    {2'd0, 4'd2,  6'h20, 32'd5,          32'd0},          // R2
    {2'd1, 4'd2,  6'h20, 32'd0,          32'd5},          // R2
    {2'd1, 4'd2,  6'h24, 32'd0,          32'd5},          // R2
    {2'd2, 4'd2,  6'h00, 32'd3,          32'd0},          // R2
    {2'd1, 4'd2,  6'h24, 32'd0,          32'd2},          // R2
    {2'd2, 4'd3,  6'h00, 32'd2,          32'h0000_0001},  // R3
    {2'd1, 4'd3,  6'h20, 32'd0,          32'd0},          // R3
    {2'd1, 4'd3,  6'h24, 32'd0,          32'd0},          // R3
    {2'd2, 4'd3,  6'h00, 32'd4,          32'd0},          // R3
    {2'd0, 4'd4,  6'h28, 32'd4,          32'd0},          // R4
    {2'd2, 4'd4,  6'h00, 32'd10,         32'h0002_0000},  // R4
    {2'd1, 4'd4,  6'h2C, 32'd0,          32'd2},          // R4
    {2'd1, 4'd4,  6'h28, 32'd0,          32'd4},          // R4
    {2'd0, 4'd5,  6'h28, 32'd0,          32'd0},          // R5
    {2'd2, 4'd5,  6'h00, 32'd6,          32'd0},          // R5
    {2'd1, 4'd5,  6'h2C, 32'd0,          32'd0},          // R5
    {2'd0, 4'd6,  6'h20, 32'd7,          32'd0},          // R6
    {2'd2, 4'd6,  6'h00, 32'd4,          32'd0},          // R6
    {2'd0, 4'd6,  6'h20, 32'd6,          32'd0},          // R6
    {2'd2, 4'd6,  6'h00, 32'd5,          32'd0},          // R6
    {2'd1, 4'd6,  6'h24, 32'd0,          32'd1},          // R6
    {2'd2, 4'd6,  6'h00, 32'd1,          32'h0000_0001},  // R6
    {2'd0, 4'd9,  6'h28, 32'd3,          32'd0},          // R9
    {2'd0, 4'd9,  6'h2C, 32'h55,         32'd0},          // R9
    {2'd1, 4'd9,  6'h2C, 32'd0,          32'd3},          // R9
    {2'd0, 4'd9,  6'h28, 32'd0,          32'd0},          // R9
    {2'd1, 4'd10, 6'h00, 32'd0,          32'd0},          // R10
    {2'd0, 4'd2,  6'h20, 32'h1234_5678,  32'd0},          // R2
    {2'd1, 4'd2,  6'h24, 32'd0,          32'h1234_5678}   // R2
  };

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int cdn, prn;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check("R1 err", {31'd0, err_o}, 32'd0);
    check("R1 pulses", {30'd0, cd_expire_o, per_expire_o}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[v][73:70], v);
      case (VEC[v][75:74])
        2'd0: bus_wr(VEC[v][69:64], 3'd4, VEC[v][63:32]);
        2'd1: begin
          bus_rd(VEC[v][69:64], 3'd4, rd);
          check(tag, rd, VEC[v][31:0]);
        end
        default: begin
          run_ticks(int'(VEC[v][63:32]), cdn, prn);
          check(tag, {prn[15:0], cdn[15:0]}, VEC[v][31:0]);
        end
      endcase
    end
    bus_wr(6'h20, 3'd4, 32'd0);

    // R7: write on the expiring tick
    bus_wr(6'h20, 3'd4, 32'd2);
    run_ticks(1, cdn, prn);
    @(negedge clk_i);
    tick_i = 1'b1; req_i = 1'b1; we_i = 1'b1; addr_i = 6'h20; size_i = 3'd4; wdata_i = 32'd9;
    #1 check("R7 no pulse", {31'd0, cd_expire_o}, 32'd0);
    @(negedge clk_i);
    tick_i = 1'b0; req_i = 1'b0; we_i = 1'b0;
    bus_rd(6'h24, 3'd4, rd);
    check("R7 loaded", rd, 32'd9);

    // R11: idle cycles hold the count
    repeat (6) @(negedge clk_i);
    bus_rd(6'h24, 3'd4, rd);
    check("R11 hold", rd, 32'd9);

    // R8: bad-size accesses
    check("R8 err before", {31'd0, err_o}, 32'd0);
    bus_wr(6'h20, 3'd2, 32'd3);
    check("R8 err set", {31'd0, err_o}, 32'd1);
    bus_rd(6'h20, 3'd4, rd);
    check("R8 no write", rd, 32'd9);
    bus_rd(6'h20, 3'd1, rd);
    check("R8 bad read", rd, 32'd0);
    repeat (3) @(negedge clk_i);
    check("R8 sticky", {31'd0, err_o}, 32'd1);

    // R1: reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1 check("R1 err after reset", {31'd0, err_o}, 32'd0);
    bus_rd(6'h24, 3'd4, rd);
    check("R1 left after reset", rd, 32'd0);
    bus_rd(6'h20, 3'd4, rd);
    check("R1 set after reset", rd, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule